// File: doc/BRIEF.md
# Predicated Saturating Vector Multiply-High Unit

This block takes one vector multiply-high operation per clock on two 128-bit operands. The operands are split into signed lanes of 8, 16 or 32 bits. For each lane the unit forms the doubled product of the two elements and keeps its upper half. The 32-bit instruction word selects one of two forms: a truncating form, or a rounding form that adds half of the discarded weight before the shift. When the doubled product does not fit in the lane, the lane result is clamped to the largest positive value.

A 16-bit predicate has one bit per destination byte. The surrounding pipeline passes in the current destination value so that bytes whose predicate bit is clear keep their old contents. A sticky cumulative saturation flag is set when a lane saturates and that lane's lowest predicate bit is active. Only reset clears the flag. The instruction word is decoded inside the unit. A word that does not match the operation encoding, or that carries the reserved size code, leaves the destination and the flag unchanged.

The merged destination, the flag and a valid strobe are registered, so they appear one clock after the operation is presented.

Top module: `vqmh_unit`

## Requirements
- R1: Bits [21:20] of the instruction word select the lane width: 00 for 8-bit lanes (16 lanes), 01 for 16-bit lanes (8 lanes), 10 for 32-bit lanes (4 lanes). Lane e occupies bits [e*W+W-1 : e*W] of each operand.
- R2: When bit 28 is 0 (truncating form), each lane result is floor(2*n*m / 2^W) for signed elements n and m.
- R3: When bit 28 is 1 (rounding form), each lane result is floor((2*n*m + 2^(W-1)) / 2^W).
- R4: When both elements of a lane hold the most negative lane value, the result is the largest positive lane value and the lane reports saturation. No other operand pair saturates.
- R5: Destination byte i takes the computed byte when predicate bit i is 1. Otherwise it takes byte i of the old destination input.
- R6: The sticky flag is set when a saturating lane has its lowest predicate bit (bit e*W/8) set. A saturating lane whose lowest predicate bit is clear does not set the flag, even if its upper bits are set.
- R7: Only reset clears the flag. An operation in which no active lane saturates leaves it unchanged.
- R8: An operation is legal only when bits [31:29]=111, [27:24]=1111, [23]=0, [16]=0, [12]=0, [11:8]=1011, [6]=1, [4]=0, [0]=0 and size is not 11. An illegal operation returns the old destination unchanged and leaves the flag unchanged.
- R9: The destination output, the flag and the valid output update on the clock edge that samples in_valid high. The valid output is high for exactly the cycle after each accepted operation. The destination output holds its value while in_valid is low.
- R10: Synchronous active-high reset clears the valid output, the destination output and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| insn | input | 32 | Instruction word (form, size, fixed fields) |
| vec_a | input | 128 | First operand vector |
| vec_b | input | 128 | Second operand vector |
| dest_old | input | 128 | Current destination contents |
| pred | input | 16 | Per-byte write predicate |
| out_valid | output | 1 | Result registered this cycle |
| dest_new | output | 128 | Merged destination result |
| sat_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
On every cycle the assertions check four things. The valid output follows in_valid by one clock. The flag never falls outside reset. Masked bytes and illegal words return the old destination, and illegal words also leave the flag alone. Saturation in a wide lane appears only for the most-negative operand pair. The arithmetic itself can only be shown by the bench's scenarios. These cover the truncating and rounding results at each width, the exact rounding boundary, and the rule that a saturating lane raises the flag only through its lowest predicate bit. A behavioural model checks them against directed corner vectors and random predicates.

// File: rtl/vqmh_pkg.sv
package vqmh_pkg;

  typedef enum logic [1:0] {
    ESZ_8   = 2'b00,
    ESZ_16  = 2'b01,
    ESZ_32  = 2'b10,
    ESZ_BAD = 2'b11
  } esz_e;

  typedef struct packed {
    logic legal;
    logic rnd;
    esz_e esz;
  } op_t;

endpackage

// File: rtl/vqmh_decode.sv
module vqmh_decode
  import vqmh_pkg::*;
(
  input  logic [31:0] insn,
  output op_t         op
);

  logic fixed_ok;
  logic unused_reg_fields;

  always_comb begin
    fixed_ok = (insn[31:29] == 3'b111) && (insn[27:24] == 4'b1111) &&
               !insn[23] && !insn[16] && !insn[12] &&
               (insn[11:8] == 4'b1011) && insn[6] && !insn[4] && !insn[0];
    op.rnd   = insn[28];
    op.esz   = esz_e'(insn[21:20]);
    op.legal = fixed_ok && (insn[21:20] != 2'b11);
  end

  // register index fields are handled outside this unit
  assign unused_reg_fields = ^{insn[22], insn[19:17], insn[15:13],
                               insn[7], insn[5], insn[3:1]};

endmodule

// File: rtl/vqmh_lane.sv
module vqmh_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         rnd,
  output logic [W-1:0] res,
  output logic         sat
);

  localparam int SW = 2 * W + 1;
  localparam logic signed [SW-1:0] MAXV = {{(W + 2){1'b0}}, {(W - 1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(W + 2){1'b1}}, {(W - 1){1'b0}}};

  logic signed [2*W-1:0] prod;
  logic signed [SW-1:0]  rc;
  logic signed [SW-1:0]  acc;
  logic signed [SW-1:0]  hi;

  always_comb begin
    prod      = $signed(a) * $signed(b);
    rc        = '0;
    rc[W-2]   = rnd;
    acc       = $signed({prod[2*W-1], prod}) + rc;
    hi        = acc >>> (W - 1);
    sat       = 1'b0;
    res       = hi[W-1:0];
    if (hi > MAXV) begin
      res = MAXV[W-1:0];
      sat = 1'b1;
    end else if (hi < MINV) begin
      res = MINV[W-1:0];
      sat = 1'b1;
    end
  end

endmodule

// File: rtl/vqmh_laneset.sv
module vqmh_laneset #(
  parameter int VEC_W = 128,
  parameter int W     = 16
) (
  input  logic [VEC_W-1:0]   a,
  input  logic [VEC_W-1:0]   b,
  input  logic               rnd,
  output logic [VEC_W-1:0]   res,
  output logic [VEC_W/W-1:0] sat
);

  localparam int NL = VEC_W / W;

  for (genvar e = 0; e < NL; e++) begin : g_lane
    vqmh_lane #(.W(W)) lane_i (
      .a   (a[e*W +: W]),
      .b   (b[e*W +: W]),
      .rnd (rnd),
      .res (res[e*W +: W]),
      .sat (sat[e])
    );
  end

endmodule

// File: rtl/vqmh_unit.sv
module vqmh_unit
  import vqmh_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [31:0]        insn,
  input  logic [VEC_W-1:0]   vec_a,
  input  logic [VEC_W-1:0]   vec_b,
  input  logic [VEC_W-1:0]   dest_old,
  input  logic [VEC_W/8-1:0] pred,
  output logic               out_valid,
  output logic [VEC_W-1:0]   dest_new,
  output logic               sat_flag
);

  localparam int NB  = VEC_W / 8;
  localparam int N16 = VEC_W / 16;
  localparam int N32 = VEC_W / 32;

  op_t              op;
  logic [VEC_W-1:0] res8, res16, res32, res_sel, merged;
  logic [NB-1:0]    sat8;
  logic [N16-1:0]   sat16;
  logic [N32-1:0]   sat32;
  logic             any_sat;

  vqmh_decode dec_i (.insn(insn), .op(op));

  vqmh_laneset #(.VEC_W(VEC_W), .W(8)) ls8_i (
    .a(vec_a), .b(vec_b), .rnd(op.rnd), .res(res8), .sat(sat8));
  vqmh_laneset #(.VEC_W(VEC_W), .W(16)) ls16_i (
    .a(vec_a), .b(vec_b), .rnd(op.rnd), .res(res16), .sat(sat16));
  vqmh_laneset #(.VEC_W(VEC_W), .W(32)) ls32_i (
    .a(vec_a), .b(vec_b), .rnd(op.rnd), .res(res32), .sat(sat32));

  // width select and flag contribution from lanes whose first byte is active
  always_comb begin
    res_sel = res8;
    any_sat = 1'b0;
    case (op.esz)
      ESZ_8: begin
        res_sel = res8;
        for (int e = 0; e < NB; e++) any_sat |= sat8[e] & pred[e];
      end
      ESZ_16: begin
        res_sel = res16;
        for (int e = 0; e < N16; e++) any_sat |= sat16[e] & pred[2*e];
      end
      ESZ_32: begin
        res_sel = res32;
        for (int e = 0; e < N32; e++) any_sat |= sat32[e] & pred[4*e];
      end
      default: begin
        res_sel = res8;
        any_sat = 1'b0;
      end
    endcase
  end

  always_comb begin
    for (int i = 0; i < NB; i++)
      merged[i*8 +: 8] = (op.legal && pred[i]) ? res_sel[i*8 +: 8] : dest_old[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dest_new  <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dest_new <= merged;
        if (op.legal && any_sat) sat_flag <= 1'b1;
      end
    end
  end

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    sat_flag |=> sat_flag);
  assert_illegal_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op.legal) |=> (dest_new == $past(dest_old) && sat_flag == $past(sat_flag)));

  for (genvar i = 0; i < NB; i++) begin : g_mask_chk
    assert_masked_byte_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !pred[i]) |=> dest_new[i*8 +: 8] == $past(dest_old[i*8 +: 8]));
  end

  for (genvar k = 0; k < N32; k++) begin : g_sat_chk
    assert_sat_min_only_R4: assert property (@(posedge clk) disable iff (rst)
      sat32[k] |-> (vec_a[k*32 +: 32] == 32'h8000_0000 && vec_b[k*32 +: 32] == 32'h8000_0000));
  end

endmodule

// File: tb/vqmh_unit_tb_top.sv
`timescale 1ns/1ps
module vqmh_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] vec_a = '0, vec_b = '0, dest_old = '0;
  logic [15:0]  pred = '0;
  logic         out_valid;
  logic [127:0] dest_new;
  logic         sat_flag;

  int total = 0;
  int bad = 0;
  bit exp_flag = 1'b0;
  logic [127:0] exp_dest = '0;

  always #2 clk = ~clk;

  vqmh_unit #(.VEC_W(128)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .vec_a(vec_a), .vec_b(vec_b), .dest_old(dest_old), .pred(pred),
    .out_valid(out_valid), .dest_new(dest_new), .sat_flag(sat_flag));

  function automatic logic [31:0] mk(bit rnd, logic [1:0] sz);
    return {3'b111, rnd, 4'b1111, 1'b0, 1'b0, sz, 3'b000, 1'b0, 3'b000, 1'b0,
            4'b1011, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0};
  endfunction

  function automatic longint sext(logic [127:0] v, int pos, int w);
    longint x;
    logic [127:0] t;
    t = v >> pos;
    x = longint'(t[63:0]) & ((64'sd1 <<< w) - 1);
    if (x >= (64'sd1 <<< (w - 1))) x = x - (64'sd1 <<< w);
    return x;
  endfunction

  // behavioural reference for one operation
  function automatic void model(input logic [31:0] ins, input logic [127:0] a, b, old,
                                input logic [15:0] p, output logic [127:0] d, output bit s);
    bit ok;
    int esz, w;
    d = old;
    s = 1'b0;
    ok = ins[31:29] == 3'b111 && ins[27:24] == 4'hF && !ins[23] && !ins[16] && !ins[12]
         && ins[11:8] == 4'hB && ins[6] && !ins[4] && !ins[0] && ins[21:20] != 2'b11;
    if (!ok) return;
    esz = 1 << ins[21:20];
    w = 8 * esz;
    for (int e = 0; e < 16 / esz; e++) begin
      longint n, m, r, mx;
      logic [63:0] rb;
      n = sext(a, e * w, w);
      m = sext(b, e * w, w);
      mx = (64'sd1 <<< (w - 1)) - 1;
      r = (n * m + (ins[28] ? (64'sd1 <<< (w - 2)) : 64'sd0)) >>> (w - 1);
      if (r > mx) begin
        r = mx;
        if (p[e * esz]) s = 1'b1;
      end
      rb = r;
      for (int j = 0; j < esz; j++)
        if (p[e * esz + j]) d[(e * esz + j) * 8 +: 8] = rb[j * 8 +: 8];
    end
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(string tag, logic [31:0] ins, logic [127:0] a, b, old, logic [15:0] p);
    logic [127:0] d;
    bit s;
    @(negedge clk);
    in_valid = 1'b1; insn = ins; vec_a = a; vec_b = b; dest_old = old; pred = p;
    model(ins, a, b, old, p, d, s);
    exp_dest = d;
    exp_flag = exp_flag | s;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " dest"}, dest_new, exp_dest);
    chk("R6 R7 flag", {127'd0, sat_flag}, {127'd0, exp_flag});
    chk("R9 valid", {127'd0, out_valid}, 128'd1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    exp_flag = 1'b0;
    exp_dest = '0;
    chk("R10 reset dest", dest_new, 128'd0);
    chk("R10 reset flag", {127'd0, sat_flag}, 128'd0);
    chk("R10 reset valid", {127'd0, out_valid}, 128'd0);
  endtask

  function automatic logic [127:0] put_min(logic [127:0] v, int esz, int e);
    for (int j = 0; j < esz; j++)
      v[(e * esz + j) * 8 +: 8] = (j == esz - 1) ? 8'h80 : 8'h00;
    return v;
  endfunction

  logic [127:0] rnd_a, rnd_b, rnd_o;
  bit done = 1'b0;

  initial begin
    logic [127:0] mn8, mn16, mn32, old;
    mn8  = {16{8'h80}};
    mn16 = {8{16'h8000}};
    mn32 = {4{32'h8000_0000}};
    old  = {16{8'h5A}};
    do_reset();

    // R2/R3 known values: 8-bit 0x40*0x40 -> 0x20; rounding boundary 0x01*0x40
    op("R1 R2 trunc 8", mk(0, 2'b00), {16{8'h40}}, {16{8'h40}}, old, 16'hFFFF);
    chk("R2 lane value", dest_new, {16{8'h20}});
    op("R3 round 8", mk(1, 2'b00), {16{8'h01}}, {16{8'h40}}, old, 16'hFFFF);
    chk("R3 lane value", dest_new, {16{8'h01}});
    op("R2 trunc 8 neg", mk(0, 2'b00), {16{8'hFF}}, {16{8'h01}}, old, 16'hFFFF);
    chk("R2 negative floor", dest_new, {16{8'hFF}});
    op("R1 R2 trunc 16", mk(0, 2'b01), {8{16'h1234}}, {8{16'hC000}}, old, 16'hFFFF);
    op("R1 R3 round 32", mk(1, 2'b10), {4{32'h7FFF_FFFF}}, {4{32'h0000_0003}}, old, 16'hFFFF);
    op("R5 partial mask", mk(1, 2'b01), {8{16'h7654}}, {8{16'h3210}}, old, 16'hA5C3);
    op("R5 no mask", mk(0, 2'b10), {4{32'h1111_2222}}, {4{32'h3333_4444}}, old, 16'h0000);
    chk("R5 no mask keeps old", dest_new, old);
    // saturating lanes with only upper bytes enabled: flag stays clear
    op("R4 R6 upper bytes only 16", mk(0, 2'b01), mn16, mn16, old, 16'hAAAA);
    chk("R6 flag not raised", {127'd0, sat_flag}, 128'd0);
    op("R4 R6 upper bytes only 32", mk(1, 2'b10), mn32, mn32, old, 16'hEEEE);
    chk("R4 saturated upper bytes", dest_new, {4{32'h7FFF_FF5A}});
    // R8 illegal: reserved size, and a wrong fixed field, with saturating operands
    op("R8 bad size", mk(0, 2'b11), mn8, mn8, old, 16'hFFFF);
    chk("R8 old kept", dest_new, old);
    op("R8 bad field", mk(1, 2'b00) ^ 32'h0000_0040, mn8, mn8, old, 16'hFFFF);
    chk("R8 flag unchanged", {127'd0, sat_flag}, 128'd0);
    // R6 active lane saturates
    op("R4 R6 sat 8", mk(0, 2'b00), mn8, mn8, old, 16'h0001);
    chk("R6 flag raised", {127'd0, sat_flag}, 128'd1);
    op("R7 sticky", mk(0, 2'b00), {16{8'h10}}, {16{8'h10}}, old, 16'hFFFF);
    chk("R7 flag kept", {127'd0, sat_flag}, 128'd1);
    // R9 idle: output holds, valid low
    @(negedge clk);
    chk("R9 idle valid", {127'd0, out_valid}, 128'd0);
    chk("R9 idle hold", dest_new, exp_dest);
    do_reset();

    for (int t = 0; t < 400; t++) begin
      int sz, esz;
      sz = $urandom_range(0, 3);
      esz = (sz == 3) ? 1 : (1 << sz);
      rnd_a = {$urandom, $urandom, $urandom, $urandom};
      rnd_b = {$urandom, $urandom, $urandom, $urandom};
      rnd_o = {$urandom, $urandom, $urandom, $urandom};
      for (int e = 0; e < 16 / esz; e++)
        if ($urandom_range(0, 5) == 0) begin
          rnd_a = put_min(rnd_a, esz, e);
          rnd_b = put_min(rnd_b, esz, e);
        end
      if (t % 50 == 49) do_reset();
      op("R1 R2 R3 R5 random", mk(1'($urandom_range(0, 1)), 2'(sz)), rnd_a, rnd_b, rnd_o,
         16'($urandom));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule